// File: doc/BRIEF.md
# DDR3 Command Spacing Monitor

This block is a passive observer placed beside a DDR3 memory controller. Each controller clock carries four DRAM-clock command slots. The monitor decodes the four slots and gives every PRECHARGE, ACTIVATE, READ and WRITE a time stamp in DRAM clocks. It keeps one stamp per command type for each of the eight banks. It then tests four minimum spacings inside each bank: ACTIVATE to column access, PRECHARGE to ACTIVATE, ACTIVATE to PRECHARGE, and READ to PRECHARGE. The four limits are parameters given in DRAM clocks.

A free-running count moves forward by the number of slots on every controller clock. A command in slot k is stamped with that count plus k, so commands that share one controller clock are still kept in order. The first spacing breach sets a flag that stays set. The monitor also records a code for the rule that was broken and the bank where it happened. These outputs hold until reset. The monitor drives nothing toward the memory and is meant for simulation, emulation or on-chip debug of a controller.

Top module: `ddr_cmd_spacing_mon`

## Requirements
- R1: Slot k uses bits [4k+3:4k] of the control bus, ordered chip-select, RAS, CAS, WE from the most significant bit. PRECHARGE (4'b0010) is decoded only in slot 0, ACTIVATE (4'b0011) only in slot 1, WRITE (4'b0100) only in slot 2 and READ (4'b0101) only in slot 3. A command code found in any other slot is ignored. Slot k uses bank bits [3k+2:3k] and address-bit-10 bit k.
- R2: After reset the time base is 0. It grows by 4 on every clock. A command decoded in slot k is stamped with the time base plus k.
- R3: A READ or WRITE whose stamp is less than T_RCD (default 11) after the latest ACTIVATE stamp of the same bank is a violation with type code 0.
- R4: An ACTIVATE whose stamp is less than T_RP (default 13) after the latest PRECHARGE stamp of the same bank is a violation with type code 1. A gap of exactly T_RP is legal.
- R5: A PRECHARGE whose stamp is less than T_RAS (default 28) after the latest ACTIVATE stamp of the same bank is a violation with type code 2.
- R6: A PRECHARGE whose stamp is less than T_RTP (default 4) after the latest READ stamp of the same bank is a violation with type code 3.
- R7: A rule is tested only against a stamp recorded in the same bank since reset. Commands to one bank never affect the checks of another bank.
- R8: A PRECHARGE with its address bit 10 set is applied to all eight banks. It is checked against, and updates, the stamps of every bank.
- R9: Commands that share one controller clock are ordered by slot. A command in a lower slot counts as earlier than a command in a higher slot.
- R10: When the first violation is seen, the flag output goes high on the following clock edge, together with the type code and the bank. All three then stay fixed until reset, whatever follows.
- R11: If several violations appear in the same clock, the lowest bank number is reported. Within that bank, the lowest type code is reported.
- R12: A synchronous active-high reset clears the flag, the type code, the bank output, the time base and every stored stamp. While the flag is low, the type and bank outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_ctl_i | input | 16 | Chip-select, RAS, CAS, WE for each of the four slots |
| slot_bank_i | input | 12 | Three-bit bank field for each slot |
| slot_a10_i | input | 4 | Address bit 10 for each slot |
| viol_o | output | 1 | Sticky violation flag |
| viol_kind_o | output | 2 | Type code of the first violation |
| viol_bank_o | output | 3 | Bank of the first violation |

## Verification
The spacing rules are tested with pairs of commands placed one slot position short of the limit and at or beyond it. Because the stamps move by four per clock plus the slot offset, passing the exact-limit case and failing the next-shorter case show that the slot offset is applied. The tests also cover commands to unrelated banks, a READ code placed in the wrong slot, and a precharge-all that reaches banks never named in its bank field. Further tests put two commands to the same bank in one clock to check that slot order decides which is earlier. Cases where several rules and banks fail together check which single result is reported, and later traffic after the first error checks that the first record is kept.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

    localparam int CTL_W     = 4;
    localparam int BANK_BITS = 3;
    localparam int NBANKS    = 1 << BANK_BITS;
    localparam int NTYPES    = 4;
    localparam int NKINDS    = 4;

    // chip-select, RAS, CAS, WE (msb first), all active low
    localparam logic [CTL_W-1:0] CODE_PRE = 4'b0010;
    localparam logic [CTL_W-1:0] CODE_ACT = 4'b0011;
    localparam logic [CTL_W-1:0] CODE_WR  = 4'b0100;
    localparam logic [CTL_W-1:0] CODE_RD  = 4'b0101;

    // index of each command type in per-bank stamp storage
    typedef enum int {
        TY_PRE = 0,
        TY_ACT = 1,
        TY_RD  = 2,
        TY_WR  = 3
    } cmd_type_e;

    // violation type codes; lower value wins on a tie
    typedef enum logic [1:0] {
        VK_RCD = 2'd0,
        VK_RP  = 2'd1,
        VK_RAS = 2'd2,
        VK_RTP = 2'd3
    } vkind_e;

    typedef struct packed {
        logic                 hit;
        logic                 all;
        logic [BANK_BITS-1:0] bank;
    } cmd_evt_t;

endpackage

// File: rtl/ddrchk_timer.sv
module ddrchk_timer #(
    parameter int TIME_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TIME_W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst) count_o <= '0;
        else     count_o <= count_o + TIME_W'(STEP);
    end

endmodule

// File: rtl/ddrchk_slot_dec.sv
module ddrchk_slot_dec
    import ddrchk_pkg::*;
#(
    parameter logic [CTL_W-1:0] CODE = CODE_PRE
) (
    input  logic [CTL_W-1:0]     ctl_i,
    input  logic [BANK_BITS-1:0] bank_i,
    input  logic                 a10_i,
    output cmd_evt_t             evt_o
);

    localparam bit IS_PRE = (CODE == CODE_PRE);

    always_comb begin
        evt_o.hit  = (ctl_i == CODE);
        evt_o.bank = bank_i;
        evt_o.all  = IS_PRE && a10_i && (ctl_i == CODE);
    end

endmodule

// File: rtl/ddrchk_bank.sv
module ddrchk_bank
    import ddrchk_pkg::*;
#(
    parameter int TIME_W   = 32,
    parameter int T_RCD    = 11,
    parameter int T_RP     = 13,
    parameter int T_RAS    = 28,
    parameter int T_RTP    = 4,
    parameter int SLOT_PRE = 0,
    parameter int SLOT_ACT = 1,
    parameter int SLOT_WR  = 2,
    parameter int SLOT_RD  = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NTYPES-1:0]              wr_i,
    input  logic [NTYPES-1:0][TIME_W-1:0]  new_i,
    output logic [NKINDS-1:0]              viol_o
);

    localparam logic [TIME_W-1:0] G_RCD = TIME_W'(T_RCD);
    localparam logic [TIME_W-1:0] G_RP  = TIME_W'(T_RP);
    localparam logic [TIME_W-1:0] G_RAS = TIME_W'(T_RAS);
    localparam logic [TIME_W-1:0] G_RTP = TIME_W'(T_RTP);
    // same-clock ordering of slot positions
    localparam bit ACT_B4_RD  = SLOT_ACT < SLOT_RD;
    localparam bit ACT_B4_WR  = SLOT_ACT < SLOT_WR;
    localparam bit ACT_B4_PRE = SLOT_ACT < SLOT_PRE;
    localparam bit PRE_B4_ACT = SLOT_PRE < SLOT_ACT;
    localparam bit RD_B4_PRE  = SLOT_RD  < SLOT_PRE;

    logic [NTYPES-1:0][TIME_W-1:0] st_q;
    logic [NTYPES-1:0]             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            seen_q <= '0;
        end else begin
            for (int t = 0; t < NTYPES; t++) begin
                if (wr_i[t]) st_q[t] <= new_i[t];
            end
            seen_q <= seen_q | wr_i;
        end
    end

    function automatic logic too_close(input logic ok, input logic [TIME_W-1:0] e,
                                       input logic [TIME_W-1:0] l,
                                       input logic [TIME_W-1:0] gap);
        return ok && (e < l) && ((l - e) < gap);
    endfunction

    // earlier stamp seen by each later command: same-clock one if its slot comes first
    logic              use_act_rd, use_act_wr, use_act_pre, use_pre_act, use_rd_pre;
    logic [TIME_W-1:0] act_for_rd, act_for_wr, act_for_pre, pre_for_act, rd_for_pre;

    always_comb begin
        use_act_rd  = ACT_B4_RD  && wr_i[TY_ACT];
        use_act_wr  = ACT_B4_WR  && wr_i[TY_ACT];
        use_act_pre = ACT_B4_PRE && wr_i[TY_ACT];
        use_pre_act = PRE_B4_ACT && wr_i[TY_PRE];
        use_rd_pre  = RD_B4_PRE  && wr_i[TY_RD];
        act_for_rd  = use_act_rd  ? new_i[TY_ACT] : st_q[TY_ACT];
        act_for_wr  = use_act_wr  ? new_i[TY_ACT] : st_q[TY_ACT];
        act_for_pre = use_act_pre ? new_i[TY_ACT] : st_q[TY_ACT];
        pre_for_act = use_pre_act ? new_i[TY_PRE] : st_q[TY_PRE];
        rd_for_pre  = use_rd_pre  ? new_i[TY_RD]  : st_q[TY_RD];

        viol_o[VK_RCD] =
            (wr_i[TY_RD] && too_close(seen_q[TY_ACT] || use_act_rd, act_for_rd,
                                      new_i[TY_RD], G_RCD)) ||
            (wr_i[TY_WR] && too_close(seen_q[TY_ACT] || use_act_wr, act_for_wr,
                                      new_i[TY_WR], G_RCD));
        viol_o[VK_RP]  = wr_i[TY_ACT] &&
            too_close(seen_q[TY_PRE] || use_pre_act, pre_for_act, new_i[TY_ACT], G_RP);
        viol_o[VK_RAS] = wr_i[TY_PRE] &&
            too_close(seen_q[TY_ACT] || use_act_pre, act_for_pre, new_i[TY_PRE], G_RAS);
        viol_o[VK_RTP] = wr_i[TY_PRE] &&
            too_close(seen_q[TY_RD] || use_rd_pre, rd_for_pre, new_i[TY_PRE], G_RTP);
    end

endmodule

// File: rtl/ddr_cmd_spacing_mon.sv
module ddr_cmd_spacing_mon
    import ddrchk_pkg::*;
#(
    parameter int SLOTS    = 4,
    parameter int TIME_W   = 32,
    parameter int T_RCD    = 11,
    parameter int T_RP     = 13,
    parameter int T_RAS    = 28,
    parameter int T_RTP    = 4,
    parameter int SLOT_PRE = 0,
    parameter int SLOT_ACT = 1,
    parameter int SLOT_WR  = 2,
    parameter int SLOT_RD  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SLOTS*CTL_W-1:0]     slot_ctl_i,
    input  logic [SLOTS*BANK_BITS-1:0] slot_bank_i,
    input  logic [SLOTS-1:0]           slot_a10_i,
    output logic                       viol_o,
    output logic [1:0]                 viol_kind_o,
    output logic [BANK_BITS-1:0]       viol_bank_o
);

    localparam int               SLOT_OF [NTYPES] = '{SLOT_PRE, SLOT_ACT, SLOT_RD, SLOT_WR};
    localparam logic [CTL_W-1:0] CODE_OF [NTYPES] = '{CODE_PRE, CODE_ACT, CODE_RD, CODE_WR};

    logic [TIME_W-1:0] timer_q;

    ddrchk_timer #(.TIME_W(TIME_W), .STEP(SLOTS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .count_o (timer_q)
    );

    cmd_evt_t                      evt [NTYPES];
    logic [NTYPES-1:0][TIME_W-1:0] stamp_new;
    logic [NTYPES-1:0]             hit_vec;
    logic                          cmd_any;

    for (genvar t = 0; t < NTYPES; t++) begin : g_type
        ddrchk_slot_dec #(.CODE(CODE_OF[t])) u_dec (
            .ctl_i  (slot_ctl_i[SLOT_OF[t]*CTL_W +: CTL_W]),
            .bank_i (slot_bank_i[SLOT_OF[t]*BANK_BITS +: BANK_BITS]),
            .a10_i  (slot_a10_i[SLOT_OF[t]]),
            .evt_o  (evt[t])
        );
        assign stamp_new[t] = timer_q + TIME_W'(SLOT_OF[t]);
        assign hit_vec[t]   = evt[t].hit;
    end

    assign cmd_any = |hit_vec;

    logic [NBANKS-1:0][NKINDS-1:0] bank_viol;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [NTYPES-1:0] wr_b;
        for (genvar t = 0; t < NTYPES; t++) begin : g_sel
            assign wr_b[t] = evt[t].hit &&
                             ((evt[t].bank == BANK_BITS'(b)) || evt[t].all);
        end
        ddrchk_bank #(
            .TIME_W(TIME_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RTP(T_RTP),
            .SLOT_PRE(SLOT_PRE), .SLOT_ACT(SLOT_ACT), .SLOT_WR(SLOT_WR), .SLOT_RD(SLOT_RD)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_i   (wr_b),
            .new_i  (stamp_new),
            .viol_o (bank_viol[b])
        );
    end

    // lowest bank first, then lowest type code
    logic                 pick_any;
    logic [1:0]           pick_kind;
    logic [BANK_BITS-1:0] pick_bank;

    always_comb begin
        pick_any  = 1'b0;
        pick_kind = '0;
        pick_bank = '0;
        for (int b = NBANKS - 1; b >= 0; b--) begin
            if (|bank_viol[b]) begin
                pick_any  = 1'b1;
                pick_bank = BANK_BITS'(b);
                for (int k = NKINDS - 1; k >= 0; k--) begin
                    if (bank_viol[b][k]) pick_kind = 2'(k);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_o      <= 1'b0;
            viol_kind_o <= '0;
            viol_bank_o <= '0;
        end else if (!viol_o && pick_any) begin
            viol_o      <= 1'b1;
            viol_kind_o <= pick_kind;
            viol_bank_o <= pick_bank;
        end
    end

endmodule

// File: rtl/ddrchk_sva.sv
module ddrchk_sva
    import ddrchk_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int STEP   = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 viol_i,
    input logic [1:0]           kind_i,
    input logic [BANK_BITS-1:0] bank_i,
    input logic                 cmd_any_i,
    input logic [TIME_W-1:0]    timer_i
);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> timer_i == $past(timer_i) + TIME_W'(STEP)); // R2

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        viol_i |=> viol_i && $stable(kind_i) && $stable(bank_i)); // R10

    AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (rst)
        !viol_i |-> (kind_i == 2'd0) && (bank_i == '0)); // R12

    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_i) |-> $past(cmd_any_i)); // R1

    AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!viol_i && !cmd_any_i) |=> !viol_i); // R7

endmodule

bind ddr_cmd_spacing_mon ddrchk_sva #(.TIME_W(TIME_W), .STEP(SLOTS)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .viol_i    (viol_o),
    .kind_i    (viol_kind_o),
    .bank_i    (viol_bank_o),
    .cmd_any_i (cmd_any),
    .timer_i   (timer_q)
);

// File: tb/test_ddr_cmd_spacing_mon.sv
module test_ddr_cmd_spacing_mon;

    localparam int T_RCD = 11;
    localparam int T_RP  = 13;
    localparam int T_RAS = 28;
    localparam int T_RTP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] slot_ctl_i  = 16'hFFFF;
    logic [11:0] slot_bank_i = '0;
    logic [3:0]  slot_a10_i  = '0;
    logic        viol_o;
    logic [1:0]  viol_kind_o;
    logic [2:0]  viol_bank_o;

    always #2 clk = ~clk; // 250 MHz

    ddr_cmd_spacing_mon #(
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RTP(T_RTP)
    ) i_ddr_cmd_spacing_mon (
        .clk(clk), .rst(rst), .slot_ctl_i(slot_ctl_i), .slot_bank_i(slot_bank_i),
        .slot_a10_i(slot_a10_i), .viol_o(viol_o), .viol_kind_o(viol_kind_o),
        .viol_bank_o(viol_bank_o)
    );

    int total = 0;
    int fails = 0;
    string cur_req = "R12";

    // staged command for the next tick
    logic [15:0] c_ctl  = 16'hFFFF;
    logic [11:0] c_bank = '0;
    logic [3:0]  c_a10  = '0;

    // reference model: type 0 PRE, 1 ACT, 2 RD, 3 WR; -1 = never seen
    longint st [8][4];
    longint mt;
    bit         exp_v;
    logic [1:0] exp_k;
    logic [2:0] exp_b;
    bit nf;
    int nb, nk;

    function automatic int slot_of(int t);
        case (t)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [3:0] code_of(int t);
        case (t)
            0: return 4'b0010;
            1: return 4'b0011;
            2: return 4'b0101;
            default: return 4'b0100;
        endcase
    endfunction

    function automatic bit near(longint e, longint l, int m);
        return (e >= 0) && (l - e < m);
    endfunction

    task automatic note(int b, int k);
        if (!nf || b < nb || (b == nb && k < nk)) begin
            nf = 1; nb = b; nk = k;
        end
    endtask

    task automatic model_clear();
        for (int b = 0; b < 8; b++)
            for (int t = 0; t < 4; t++) st[b][t] = -1;
        mt = 0; exp_v = 0; exp_k = 0; exp_b = 0;
    endtask

    task automatic model_cycle();
        nf = 0; nb = 8; nk = 4;
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                if (slot_of(t) == s && c_ctl[s*4 +: 4] == code_of(t)) begin
                    longint sp = mt + s;
                    int b = int'(c_bank[s*3 +: 3]);
                    if (t == 0) begin
                        for (int x = 0; x < 8; x++) begin
                            if (c_a10[s] || x == b) begin
                                if (near(st[x][1], sp, T_RAS)) note(x, 2);
                                if (near(st[x][2], sp, T_RTP)) note(x, 3);
                                st[x][0] = sp;
                            end
                        end
                    end else if (t == 1) begin
                        if (near(st[b][0], sp, T_RP)) note(b, 1);
                        st[b][1] = sp;
                    end else begin
                        if (near(st[b][1], sp, T_RCD)) note(b, 0);
                        st[b][t] = sp;
                    end
                end
            end
        end
        if (!exp_v && nf) begin
            exp_v = 1; exp_k = 2'(nk); exp_b = 3'(nb);
        end
        mt = mt + 4;
    endtask

    task automatic compare_model();
        total++;
        if (viol_o !== exp_v || viol_kind_o !== exp_k || viol_bank_o !== exp_b) begin
            fails++;
            $display("FAIL %s model: got v=%0b k=%0d b=%0d expected v=%0b k=%0d b=%0d",
                     cur_req, viol_o, viol_kind_o, viol_bank_o, exp_v, exp_k, exp_b);
        end
    endtask

    task automatic check3(string req, bit v, int k, int b);
        total++;
        if (viol_o !== v || viol_kind_o !== 2'(k) || viol_bank_o !== 3'(b)) begin
            fails++;
            $display("FAIL %s: got v=%0b k=%0d b=%0d expected v=%0b k=%0d b=%0d",
                     req, viol_o, viol_kind_o, viol_bank_o, v, k, b);
        end
    endtask

    // stage a command of type t at its own slot
    task automatic put(int t, int b, bit a10 = 0);
        int s = slot_of(t);
        c_ctl[s*4 +: 4]  = code_of(t);
        c_bank[s*3 +: 3] = 3'(b);
        c_a10[s]         = a10;
    endtask

    // place a raw code in an arbitrary slot
    task automatic put_raw(int s, logic [3:0] code, int b);
        c_ctl[s*4 +: 4]  = code;
        c_bank[s*3 +: 3] = 3'(b);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic tick();
        slot_ctl_i  = c_ctl;
        slot_bank_i = c_bank;
        slot_a10_i  = c_a10;
        model_cycle();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        c_ctl = 16'hFFFF; c_bank = '0; c_a10 = '0;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        slot_ctl_i = 16'hFFFF; slot_bank_i = '0; slot_a10_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #400000;
        total++; fails++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        model_clear();
        // reset state
        do_reset();
        cur_req = "R12";
        check3("R12", 0, 0, 0);

        // legal sequence at the limits, bank 2
        do_reset(); cur_req = "R4";
        put(1, 2); tick();          // ACT @1
        wait_n(2);
        put(2, 2); tick();          // RD @15, gap 14
        wait_n(4);
        put(0, 2); tick();          // PRE @32, tRAS 31, tRTP 17
        wait_n(2);
        put(1, 2); tick();          // ACT @45, gap exactly 13
        check3("R4", 0, 0, 0);

        // READ too close to ACTIVATE, bank 6 (gap 10)
        do_reset(); cur_req = "R3";
        put(1, 6); tick();
        wait_n(1);
        put(2, 6); tick();          // RD @11
        check3("R3", 1, 0, 6);
        // later traffic must not change the record
        cur_req = "R10";
        put(0, 0); tick();
        put(1, 0); tick();
        wait_n(2);
        check3("R10", 1, 0, 6);

        // reset wipes stamps: READ alone after reset is fine
        do_reset(); cur_req = "R12";
        put(2, 6); tick();
        check3("R12", 0, 0, 0);

        // WRITE gap 13 legal, then bank 1 WRITE gap 9 illegal
        do_reset(); cur_req = "R2";
        put(1, 0); tick();
        wait_n(2);
        put(3, 0); tick();          // WR @14, gap 13
        check3("R2", 0, 0, 0);
        put(1, 1); tick();          // ACT @17
        wait_n(1);
        put(3, 1); tick();          // WR @26, gap 9
        check3("R3", 1, 0, 1);

        // ACTIVATE too soon after PRECHARGE, bank 3 (gap 9)
        do_reset(); cur_req = "R4";
        put(0, 3); tick();
        wait_n(1);
        put(1, 3); tick();
        check3("R4", 1, 1, 3);

        // PRECHARGE too soon after ACTIVATE, bank 4 (gap 27)
        do_reset(); cur_req = "R5";
        put(1, 4); tick();
        wait_n(6);
        put(0, 4); tick();
        check3("R5", 1, 2, 4);

        // PRECHARGE too soon after READ, bank 7 (gap 1)
        do_reset(); cur_req = "R6";
        put(1, 7); tick();
        wait_n(6);
        put(2, 7); tick();          // RD @31
        put(0, 7); tick();          // PRE @32
        check3("R6", 1, 3, 7);

        // unrelated banks do not interact
        do_reset(); cur_req = "R7";
        put(1, 1); tick();
        put(2, 2); tick();
        put(0, 5); tick();
        put(1, 0); tick();
        check3("R7", 0, 0, 0);

        // READ code in slot 0 is ignored
        do_reset(); cur_req = "R1";
        put(1, 4); tick();
        put_raw(0, 4'b0101, 4); tick();
        put_raw(2, 4'b0010, 4); tick();
        check3("R1", 0, 0, 0);

        // precharge-all reaches bank 5 via tRAS
        do_reset(); cur_req = "R8";
        put(1, 5); tick();
        put(0, 0, 1'b1); tick();
        check3("R8", 1, 2, 5);

        // precharge-all stamps bank 6, then ACTIVATE too early
        do_reset(); cur_req = "R8";
        put(0, 0, 1'b1); tick();
        put(1, 6); tick();
        check3("R8", 1, 1, 6);

        // same clock ACT slot 1 then READ slot 3 (gap 2)
        do_reset(); cur_req = "R9";
        put(1, 2); put(2, 2); tick();
        check3("R9", 1, 0, 2);

        // same clock PRE slot 0 then ACT slot 1 on bank 3
        do_reset(); cur_req = "R9";
        put(1, 3); tick();
        wait_n(7);
        put(0, 3); put(1, 3); tick();
        check3("R9", 1, 1, 3);

        // two banks fail together: lowest bank wins
        do_reset(); cur_req = "R11";
        put(1, 6); tick();
        put(1, 3); tick();
        put(0, 0, 1'b1); tick();
        check3("R11", 1, 2, 3);

        // two rules fail in one bank: lowest code wins
        do_reset(); cur_req = "R11";
        put(1, 2); tick();
        wait_n(2);
        put(2, 2); tick();
        put(0, 2); tick();
        check3("R11", 1, 2, 2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule